// File: doc/BRIEF.md
# Multi-Mode Interval Timer Counter

This block is one 16-bit down-counting channel of a programmable interval timer. A byte-wide bus with active-low select, read and write strobes reaches four addresses: three counter slots and a control word. Only slot 0 is built. Writes to slots 1 and 2, and control words aimed at them, are accepted on the bus and then dropped. A control word sets how the count bytes are transferred and which of six output behaviours the channel follows. After that, software writes the initial count.

Counting is driven by a separate count clock. That clock and the GATE input both pass through a synchronizer into the bus clock domain. Each rising edge of the count clock becomes a single-cycle tick. A newly written count takes effect on the first tick after the write completes. The channel produces the following OUT waveforms:

- a level that rises at terminal count;
- a gate-triggered one-shot;
- a periodic one-tick low pulse;
- a square wave;
- a one-tick strobe started by software;
- a one-tick strobe started by the gate.

Counting is binary only. A count of zero stands for 65536.

Top module: `tmr_channel`

## Requirements
- R1: A bus write happens in a clock cycle with cs_n=0, wr_n=0 and rd_n=1. A bus read happens in a cycle with cs_n=0, rd_n=0 and wr_n=1. addr=00 selects counter slot 0 and addr=11 selects the control word on a write. A cycle with cs_n high, or with both strobes high, changes nothing. A read at addr=11, like any cycle that is not a read of slot 0, returns dout=0x00.
- R2: Control word fields:
  - bits 7:6 select the counter, and only 00 has an effect;
  - bits 5:4 give the byte access, and 00 is ignored;
  - bits 3:1 give the mode, where 6 and 7 act as 2 and 3;
  - bit 0 is ignored, and counting is always binary.
  An accepted control word drives OUT low for mode 0 and high for every other mode, and halts counting until a count is written.
- R3: Byte access 01 transfers the low byte only and 10 the high byte only; the other byte is zero. Access 11 transfers the low byte first and then the high byte. The count is complete, and loads, only after the high byte. Reads of slot 0 follow the same byte order, and an accepted control word restarts both byte orders.
- R4: Writes to addr=01 and addr=10 have no effect on the channel.
- R5: Mode 0: OUT is low from the control word through the loaded count. The count loads on the first tick after it is written and then decrements once per tick. OUT goes high on the tick that reaches zero, so with count N that is tick N+1. OUT stays high until a new count or control word is written.
- R6: Modes 0, 2, 3 and 4: while GATE is low, ticks do not change the count, and a read returns the held value.
- R7: Mode 1: OUT is high after the count is written. A rising GATE edge arms the load on the next tick, which sets OUT low. OUT returns high on the tick that reaches zero. A new GATE edge before then reloads the count and extends the low time.
- R8: Mode 2 with reload N: OUT is low for exactly one tick in every N ticks, namely the tick on which the count reaches 1. The count then reloads automatically.
- R9: Mode 3 with reload N: OUT is high for ceil(N/2) ticks and then low for floor(N/2) ticks, repeating.
- R10: Mode 4: OUT stays high after the count is written. It is low for exactly one tick, on reaching zero, and then high again. A low GATE suspends counting.
- R11: Mode 5: writing the count does not start counting. A rising GATE edge loads the count on the next tick. OUT stays high until zero is reached, is low for one tick, and then returns high.
- R12: A count value of 0 loads as 65536, so the tick after the load reads back 0xFFFF.
- R13: A count write that completes in the same cycle as a tick does not block that tick. The tick acts on the old count, and the new count loads on the following tick.
- R14: After reset OUT is high and dout is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Slot select: 00/01/10 counters, 11 control |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data byte, zero when not reading slot 0 |
| cnt_clk | input | 1 | Count clock, sampled and edge-detected |
| gate | input | 1 | Gate level and trigger input |
| out | output | 1 | Counter output waveform |

## Verification
The count clock is asynchronous, so a count write can complete in exactly the cycle where the synchronized count-clock edge produces a tick. In that cycle the reload path and the decrement path both want the count register. The bench creates this coincidence by timing a slot-0 write so that it lands on the third clock edge after raising cnt_clk, which is where a two-stage synchronizer fires the tick. With a strobe-mode count of 3 already running, the bench then expects the old count to step down once and the new value 2 to load on the next tick. That places the one-tick low strobe on the third following tick, a position that differs when the write is dropped and when it preempts the decrement.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_INT_TC    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } tmr_acc_e;

  // Field values 6 and 7 fold onto the rate and square modes.
  function automatic tmr_mode_e fold_mode(input logic [2:0] field);
    if (field[1]) return tmr_mode_e'({1'b0, field[1:0]});
    else          return tmr_mode_e'(field);
  endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise
);

  logic [STAGES-1:0] sq_q, sq_d;
  logic              prev_q;

  always_comb begin
    sq_d = {sq_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sq_q   <= sq_d;
      prev_q <= sq_q[STAGES-1];
    end
  end

  assign lvl  = sq_q[STAGES-1];
  assign rise = sq_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [1:0]       addr,
  input  logic [7:0]       din,
  output logic [7:0]       dout,
  input  logic [CNT_W-1:0] cnt_now,
  output logic             ctrl_wr,
  output tmr_mode_e        ctrl_mode,
  output logic             count_wr,
  output logic [CNT_W-1:0] count_val
);

  localparam logic [1:0] SLOT0 = 2'b00;
  localparam logic [1:0] CTRL  = 2'b11;

  tmr_acc_e   acc_q, acc_d;
  logic       wr_hi_q, wr_hi_d;
  logic       rd_hi_q, rd_hi_d;
  logic [7:0] lo_hold_q, lo_hold_d;

  logic        bus_wr, bus_rd, wr_c0, rd_c0;
  logic [15:0] rd_word;
  logic        unused_bcd;

  assign bus_wr     = !cs_n && !wr_n && rd_n;
  assign bus_rd     = !cs_n && !rd_n && wr_n;
  assign wr_c0      = bus_wr && (addr == SLOT0);
  assign rd_c0      = bus_rd && (addr == SLOT0);
  assign unused_bcd = din[0];
  assign rd_word    = 16'(cnt_now);

  // control decode: only counter 0 with a real access field is taken
  always_comb begin
    ctrl_wr   = bus_wr && (addr == CTRL) && (din[7:6] == 2'b00)
                && (din[5:4] != 2'b00);
    ctrl_mode = fold_mode(din[3:1]);
  end

  // byte sequencing, next state
  always_comb begin
    acc_d     = acc_q;
    wr_hi_d   = wr_hi_q;
    rd_hi_d   = rd_hi_q;
    lo_hold_d = lo_hold_q;
    count_wr  = 1'b0;
    count_val = '0;
    if (ctrl_wr) begin
      acc_d   = tmr_acc_e'(din[5:4]);
      wr_hi_d = 1'b0;
      rd_hi_d = 1'b0;
    end else begin
      if (wr_c0) begin
        case (acc_q)
          ACC_LO: begin
            count_wr  = 1'b1;
            count_val = CNT_W'(din);
          end
          ACC_HI: begin
            count_wr  = 1'b1;
            count_val = CNT_W'({din, 8'h00});
          end
          ACC_LOHI: begin
            if (!wr_hi_q) begin
              lo_hold_d = din;
              wr_hi_d   = 1'b1;
            end else begin
              count_wr  = 1'b1;
              count_val = CNT_W'({din, lo_hold_q});
              wr_hi_d   = 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (rd_c0 && (acc_q == ACC_LOHI)) rd_hi_d = !rd_hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= ACC_LO;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      lo_hold_q <= 8'h00;
    end else begin
      acc_q     <= acc_d;
      wr_hi_q   <= wr_hi_d;
      rd_hi_q   <= rd_hi_d;
      lo_hold_q <= lo_hold_d;
    end
  end

  // read data mux
  always_comb begin
    dout = 8'h00;
    if (rd_c0) begin
      case (acc_q)
        ACC_LO:   dout = rd_word[7:0];
        ACC_HI:   dout = rd_word[15:8];
        ACC_LOHI: dout = rd_hi_q ? rd_word[15:8] : rd_word[7:0];
        default:  dout = 8'h00;
      endcase
    end
  end

  // R1: idle or deselected cycles leave the byte sequencing untouched
  p_noop_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || (rd_n && wr_n)) |=> ($stable(acc_q) && $stable(wr_hi_q) && $stable(rd_hi_q)));

  // R3: a two-byte count only completes on its second byte
  p_lohi_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_wr && acc_q == ACC_LOHI) |-> wr_hi_q);

  // R3: an accepted control word restarts both byte orders
  p_ctrl_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (!wr_hi_q && !rd_hi_q));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_lvl,
  input  logic             gate_rise,
  input  logic             ctrl_wr,
  input  tmr_mode_e        ctrl_mode,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] count_val,
  output logic             out,
  output logic [CNT_W-1:0] cnt_now
);

  localparam int            CW      = CNT_W + 1;
  localparam logic [CW-1:0] FULL    = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CW-1:0] ONE_V   = CW'(1);
  localparam logic [CW-1:0] TWO_V   = CW'(2);

  tmr_mode_e     mode_q, mode_d;
  logic [CW-1:0] reload_q, reload_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          load_pend_q, load_pend_d;
  logic          trig_pend_q, trig_pend_d;
  logic          armed_q, armed_d;
  logic          active_q, active_d;
  logic          done_q, done_d;

  logic [CW-1:0] ext_val, half_hi, half_lo, cnt_dec;
  logic          is_one, is_two, gated_mode;

  assign ext_val = (count_val == '0) ? FULL : CW'(count_val);
  assign half_hi = (reload_q + ONE_V) >> 1;
  assign half_lo = reload_q >> 1;
  assign cnt_dec = cnt_q - ONE_V;
  assign is_one  = (cnt_q == ONE_V);
  assign is_two  = (cnt_q == TWO_V);

  always_comb begin
    mode_d      = mode_q;
    reload_d    = reload_q;
    cnt_d       = cnt_q;
    out_d       = out_q;
    load_pend_d = load_pend_q;
    trig_pend_d = trig_pend_q;
    armed_d     = armed_q;
    active_d    = active_q;
    done_d      = done_q;

    if (tick) begin
      case (mode_q)
        M_INT_TC, M_SW_STROBE: begin
          if (mode_q == M_SW_STROBE && !out_q) out_d = 1'b1;
          if (load_pend_q) begin
            cnt_d       = reload_q;
            load_pend_d = 1'b0;
            active_d    = 1'b1;
            done_d      = 1'b0;
          end else if (active_q && !done_q && gate_lvl) begin
            cnt_d = cnt_dec;
            if (is_one) begin
              done_d = 1'b1;
              out_d  = (mode_q == M_INT_TC);
            end
          end
        end
        M_ONESHOT, M_HW_STROBE: begin
          if (mode_q == M_HW_STROBE && !out_q) out_d = 1'b1;
          if (trig_pend_q) begin
            trig_pend_d = 1'b0;
            if (armed_q) begin
              cnt_d    = reload_q;
              active_d = 1'b1;
              done_d   = 1'b0;
              if (mode_q == M_ONESHOT) out_d = 1'b0;
            end
          end else if (active_q && !done_q) begin
            cnt_d = cnt_dec;
            if (is_one) begin
              done_d = 1'b1;
              out_d  = (mode_q == M_ONESHOT);
            end
          end
        end
        M_RATE: begin
          if (load_pend_q) begin
            cnt_d       = reload_q;
            load_pend_d = 1'b0;
            active_d    = 1'b1;
            out_d       = (reload_q != ONE_V);
          end else if (active_q && gate_lvl) begin
            if (is_one) begin
              cnt_d = reload_q;
              out_d = 1'b1;
            end else begin
              cnt_d = cnt_dec;
              out_d = !is_two;
            end
          end
        end
        M_SQUARE: begin
          if (load_pend_q) begin
            cnt_d       = half_hi;
            load_pend_d = 1'b0;
            active_d    = 1'b1;
            out_d       = 1'b1;
          end else if (active_q && gate_lvl) begin
            if (is_one) begin
              out_d = !out_q;
              cnt_d = out_q ? half_lo : half_hi;
            end else begin
              cnt_d = cnt_dec;
            end
          end
        end
        default: ;
      endcase
    end

    // a completed count lands after the tick, so a same-cycle tick used the old count
    if (count_wr) begin
      reload_d = ext_val;
      if (mode_q == M_ONESHOT || mode_q == M_HW_STROBE) armed_d = 1'b1;
      else                                              load_pend_d = 1'b1;
      if (mode_q == M_INT_TC) out_d = 1'b0;
    end

    if (gate_rise) trig_pend_d = 1'b1;

    if (ctrl_wr) begin
      mode_d      = ctrl_mode;
      out_d       = (ctrl_mode != M_INT_TC);
      load_pend_d = 1'b0;
      trig_pend_d = 1'b0;
      armed_d     = 1'b0;
      active_d    = 1'b0;
      done_d      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_INT_TC;
      reload_q    <= '0;
      cnt_q       <= '0;
      out_q       <= 1'b1;
      load_pend_q <= 1'b0;
      trig_pend_q <= 1'b0;
      armed_q     <= 1'b0;
      active_q    <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      reload_q    <= reload_d;
      cnt_q       <= cnt_d;
      out_q       <= out_d;
      load_pend_q <= load_pend_d;
      trig_pend_q <= trig_pend_d;
      armed_q     <= armed_d;
      active_q    <= active_d;
      done_q      <= done_d;
    end
  end

  assign out     = out_q;
  assign cnt_now = cnt_q[CNT_W-1:0];

  assign gated_mode = (mode_q == M_INT_TC) || (mode_q == M_RATE) ||
                      (mode_q == M_SQUARE) || (mode_q == M_SW_STROBE);

  // R2: a mode-0 control word drives OUT low, any other mode drives it high
  p_ctrl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_mode == M_INT_TC) |=> !out_q);
  p_ctrl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_mode != M_INT_TC) |=> out_q);

  // R5: once high in mode 0, OUT holds until a new count or control word
  p_tc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_INT_TC && out_q && !ctrl_wr && !count_wr) |=> out_q);

  // R6: a low gate freezes a running count
  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !gate_lvl && gated_mode && active_q && !load_pend_q) |=> $stable(cnt_q));

  // R7: the one-shot output only moves on a tick or a control word
  p_oneshot_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONESHOT && !tick && !ctrl_wr) |=> $stable(out_q));

  // R10 / R11: a strobe low lasts a single tick
  p_strobe_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !out_q && !ctrl_wr &&
     (mode_q == M_SW_STROBE || mode_q == M_HW_STROBE)) |=> out_q);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       cnt_clk,
  input  logic       gate,
  output logic       out
);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic             tick, unused_cnt_lvl;
  logic             gate_lvl, gate_rise;
  logic             ctrl_wr, count_wr;
  tmr_mode_e        ctrl_mode;
  logic [CNT_W-1:0] count_val, cnt_now;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) i_cnt_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d    (cnt_clk),
    .lvl  (unused_cnt_lvl),
    .rise (tick)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) i_gate_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d    (gate),
    .lvl  (gate_lvl),
    .rise (gate_rise)
  );

  tmr_bus_if #(.CNT_W(CNT_W)) i_bus (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .din      (din),
    .dout     (dout),
    .cnt_now  (cnt_now),
    .ctrl_wr  (ctrl_wr),
    .ctrl_mode(ctrl_mode),
    .count_wr (count_wr),
    .count_val(count_val)
  );

  tmr_count_core #(.CNT_W(CNT_W)) i_core (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick     (tick),
    .gate_lvl (gate_lvl),
    .gate_rise(gate_rise),
    .ctrl_wr  (ctrl_wr),
    .ctrl_mode(ctrl_mode),
    .count_wr (count_wr),
    .count_val(count_val),
    .out      (out),
    .cnt_now  (cnt_now)
  );

endmodule

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;

  logic       clk;
  logic       rst_n;
  logic       cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic       cnt_clk, gate, out;

  int vectors;
  int miscompares;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .cnt_clk(cnt_clk), .gate(gate), .out(out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = dout;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic cpulse(input int n);
    repeat (n) begin
      @(negedge clk); cnt_clk = 1'b1;
      repeat (4) @(negedge clk);
      cnt_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk); gate = v;
    repeat (6) @(negedge clk);
  endtask

  // bit k of pat is the OUT level expected after tick k+1
  task automatic expect_seq(input string tag, input logic [15:0] pat, input int n);
    for (int k = 0; k < n; k++) begin
      cpulse(1);
      chk(tag, int'(out), int'(pat[k]));
    end
  endtask

  task automatic t_reset;
    chk("R14 out after reset", int'(out), 1);
    chk("R14 dout after reset", int'(dout), 0);
  endtask

  task automatic t_mode0;
    set_gate(1'b1);
    bus_wr(2'b11, 8'h10);
    chk("R5 out low after control", int'(out), 0);
    bus_wr(2'b00, 8'h04);
    expect_seq("R5 mode0 N=4", 16'h0030, 6);
  endtask

  task automatic t_gate_hold;
    logic [7:0] rd;
    set_gate(1'b1);
    bus_wr(2'b11, 8'h10);
    bus_wr(2'b00, 8'h04);
    cpulse(2);
    set_gate(1'b0);
    cpulse(5);
    bus_rd(2'b00, rd);
    chk("R6 held count", int'(rd), 3);
    chk("R6 out while held", int'(out), 0);
    set_gate(1'b1);
    cpulse(2);
    chk("R6 out before zero", int'(out), 0);
    cpulse(1);
    chk("R6 out at zero", int'(out), 1);
  endtask

  task automatic t_ignored;
    logic [7:0] rd;
    set_gate(1'b1);
    bus_wr(2'b11, 8'h10);
    bus_wr(2'b00, 8'h04);
    bus_wr(2'b01, 8'h01);
    bus_wr(2'b10, 8'h01);
    chk("R4 slot writes ignored", int'(out), 0);
    bus_wr(2'b11, 8'h54);
    chk("R2 other counter control ignored", int'(out), 0);
    bus_wr(2'b11, 8'h04);
    chk("R2 access 00 ignored", int'(out), 0);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'b11; din = 8'h12;
    @(negedge clk);
    wr_n = 1'b1;
    chk("R1 deselected write ignored", int'(out), 0);
    bus_rd(2'b11, rd);
    chk("R1 read at control addr", int'(rd), 0);
    cpulse(4);
    chk("R4 count unchanged before zero", int'(out), 0);
    cpulse(1);
    chk("R4 count unchanged at zero", int'(out), 1);
  endtask

  task automatic t_access;
    logic [7:0] rd;
    set_gate(1'b0);
    bus_wr(2'b11, 8'h30);
    bus_wr(2'b00, 8'h02);
    bus_wr(2'b00, 8'h03);
    cpulse(1);
    bus_rd(2'b00, rd);
    chk("R3 lohi read low", int'(rd), 8'h02);
    bus_rd(2'b00, rd);
    chk("R3 lohi read high", int'(rd), 8'h03);
    bus_rd(2'b00, rd);
    chk("R3 lohi read wraps", int'(rd), 8'h02);
    bus_wr(2'b11, 8'h20);
    bus_wr(2'b00, 8'h01);
    cpulse(1);
    bus_rd(2'b00, rd);
    chk("R3 high-only load", int'(rd), 8'h01);
    bus_wr(2'b11, 8'h31);
    bus_wr(2'b00, 8'h07);
    bus_wr(2'b00, 8'h00);
    cpulse(1);
    bus_rd(2'b00, rd);
    chk("R2 bcd bit ignored", int'(rd), 8'h07);
    set_gate(1'b1);
  endtask

  task automatic t_zero;
    logic [7:0] rd;
    set_gate(1'b1);
    bus_wr(2'b11, 8'h30);
    bus_wr(2'b00, 8'h00);
    bus_wr(2'b00, 8'h00);
    cpulse(2);
    bus_rd(2'b00, rd);
    chk("R12 zero count low byte", int'(rd), 8'hFF);
    bus_rd(2'b00, rd);
    chk("R12 zero count high byte", int'(rd), 8'hFF);
    chk("R12 out still low", int'(out), 0);
  endtask

  task automatic t_mode1;
    set_gate(1'b0);
    bus_wr(2'b11, 8'h12);
    chk("R7 out high after control", int'(out), 1);
    bus_wr(2'b00, 8'h03);
    cpulse(2);
    chk("R7 no trigger no start", int'(out), 1);
    set_gate(1'b1);
    cpulse(1);
    chk("R7 low on trigger", int'(out), 0);
    cpulse(2);
    chk("R7 low before zero", int'(out), 0);
    cpulse(1);
    chk("R7 high at zero", int'(out), 1);
    set_gate(1'b0);
    set_gate(1'b1);
    cpulse(3);
    set_gate(1'b0);
    set_gate(1'b1);
    cpulse(1);
    chk("R7 retrigger keeps low", int'(out), 0);
    cpulse(2);
    chk("R7 retrigger extends", int'(out), 0);
    cpulse(1);
    chk("R7 retrigger ends", int'(out), 1);
  endtask

  task automatic t_mode2;
    set_gate(1'b1);
    bus_wr(2'b11, 8'h14);
    bus_wr(2'b00, 8'h04);
    expect_seq("R8 rate N=4", 16'h0077, 8);
    bus_wr(2'b11, 8'h1C);
    bus_wr(2'b00, 8'h03);
    expect_seq("R2 mode 6 as rate N=3", 16'h001B, 6);
  endtask

  task automatic t_mode3;
    set_gate(1'b1);
    bus_wr(2'b11, 8'h16);
    bus_wr(2'b00, 8'h05);
    expect_seq("R9 square odd N=5", 16'h00E7, 10);
    bus_wr(2'b11, 8'h16);
    bus_wr(2'b00, 8'h04);
    expect_seq("R9 square even N=4", 16'h0033, 8);
  endtask

  task automatic t_mode4;
    set_gate(1'b1);
    bus_wr(2'b11, 8'h18);
    bus_wr(2'b00, 8'h03);
    expect_seq("R10 sw strobe N=3", 16'h0037, 6);
    bus_wr(2'b00, 8'h03);
    cpulse(2);
    set_gate(1'b0);
    cpulse(3);
    chk("R10 gate low suspends", int'(out), 1);
    set_gate(1'b1);
    cpulse(1);
    chk("R10 resumed before zero", int'(out), 1);
    cpulse(1);
    chk("R10 strobe after resume", int'(out), 0);
    cpulse(1);
    chk("R10 strobe ends", int'(out), 1);
  endtask

  task automatic t_mode5;
    set_gate(1'b0);
    bus_wr(2'b11, 8'h1A);
    bus_wr(2'b00, 8'h03);
    cpulse(3);
    chk("R11 no start without gate edge", int'(out), 1);
    set_gate(1'b1);
    expect_seq("R11 hw strobe N=3", 16'h0017, 5);
  endtask

  task automatic t_collide;
    set_gate(1'b1);
    bus_wr(2'b11, 8'h18);
    bus_wr(2'b00, 8'h03);
    cpulse(1);
    // write lands on the edge where the synchronized tick fires
    @(negedge clk); cnt_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 2'b00; din = 8'h02;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    cnt_clk = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 out after collision", int'(out), 1);
    expect_seq("R13 new count on next tick", 16'h000B, 4);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL all: watchdog got running expected finished");
    summary();
    $finish;
  end

  initial begin
    vectors = 0; miscompares = 0;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = 2'b00; din = 8'h00; cnt_clk = 1'b0; gate = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_mode0();
    t_gate_hold();
    t_ignored();
    t_access();
    t_zero();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_collide();
    summary();
    $finish;
  end

endmodule